// File: doc/BRIEF.md
# Rectangular Frame-Buffer Transfer Engine

This engine copies a rectangle of 16-bit pixels between a host word stream and a 1024 x 512 pixel memory. The host first sends a three-word header: an opcode word that selects the direction, a position word and a size word. After the header, data words carry two pixels each.

For a write, the engine accepts data words and stores their pixels in row-major order. For a read, it fetches pixels from memory, packs them into words and offers them to the host. The host may pause at any word, so one rectangle can be spread over any number of bursts. The engine keeps its row, its column offset and the remaining height across these pauses. It handles one pixel per memory access and waits one cycle for read data.

The controller is a single state machine with these states:
- `S_IDLE`: waits for an opcode.
- `S_POS`: takes the position word.
- `S_SIZE`: takes the size word and loads the raster walker.
- Write path: `S_WTAKE` accepts a data word, `S_WLO` stores its low pixel, `S_WHI` stores its high pixel, and `S_WFIN` issues the completion pulse.
- Read path: `S_RLO` requests the low pixel, `S_RCAPLO` captures it and requests the high pixel, `S_RCAPHI` captures the high pixel, and `S_ROUT` offers the word.

The transitions are:
- IDLE→POS on a transfer opcode. Any other opcode leaves the engine in IDLE.
- POS→SIZE.
- SIZE→RLO for a read, or SIZE→WTAKE for a write.
- WTAKE→WLO.
- WLO→WHI, or WLO→WFIN when the pixel just stored was the last one.
- WHI→WTAKE, or WHI→WFIN when the pixel just stored was the last one.
- WFIN→IDLE.
- RLO→RCAPLO.
- RCAPLO→RCAPHI, or RCAPLO→ROUT when the height is used up.
- RCAPHI→ROUT.
- ROUT→RLO on a pop while pixels remain, or ROUT→IDLE on the final pop.

Top module: `fb_rect_xfer`

## Requirements
- R1: After reset, `busy`, `img_ready`, `rd_valid`, `mem_we`, `mem_re` and `wr_done` are low and `in_ready` is high.
- R2: The opcode is taken from bits 31:24 of the first header word. Opcodes 0xA0–0xBF start a write. Opcodes 0xC0–0xDF start a read, which is detected as (opcode AND 0xE0) == 0xC0. Any other first word is consumed and ignored: `busy` stays low and no memory access occurs.
- R3: In the position word, the X start is bits 9:0 and the Y start is bits 24:16. All other bits of the position word are ignored.
- R4: In the size word, the width is ((bits 15:0 − 1) AND 0x3FF) + 1 and the height is ((bits 31:16 − 1) AND 0x1FF) + 1. A zero field therefore gives a width of 1024 or a height of 512.
- R5: Pixel k of the stream goes to address row × 1024 + column. Here column = X + (k mod width) and row = Y + (k div width). The low halfword of each data word is pixel 2j and the high halfword is pixel 2j+1.
- R6: Pauses on `in_valid` or `rd_pop` do not disturb the transfer. A pending read word stays stable until it is popped, and a data word may straddle two rows.
- R7: The column wraps modulo 1024 and the row wraps modulo 512.
- R8: A transfer performs exactly width × height pixel accesses. If the pixel count is odd, the high halfword of the last write word is ignored.
- R9: One cycle after the last pixel of a write is stored, `wr_done` pulses high for a single cycle. At that point `done_x`, `done_y`, `done_w` and `done_h` report the original rectangle.
- R10: When a read starts, the first word is fetched before `rd_valid` first rises. It holds pixels 0 and 1 of the rectangle.
- R11: `img_ready` rises when a read header completes and falls after the last read word is popped. It is high only while `busy` is high.
- R12: For a read with an odd pixel count, the high halfword of the last word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a header or data word |
| in_data | input | 32 | Host header or data word |
| in_ready | output | 1 | Engine accepts `in_data` this cycle |
| rd_valid | output | 1 | Read word available |
| rd_data | output | 32 | Read word, with the earlier pixel in the low halfword |
| rd_pop | input | 1 | Host takes the read word |
| mem_addr | output | 19 | Pixel address {row, column} |
| mem_we | output | 1 | Pixel write strobe |
| mem_wdata | output | 16 | Pixel write data |
| mem_re | output | 1 | Pixel read strobe, with data returned the next cycle |
| mem_rdata | input | 16 | Pixel read data |
| busy | output | 1 | A transfer header or transfer is in progress |
| img_ready | output | 1 | A read transfer is active |
| wr_done | output | 1 | Single-cycle write completion pulse |
| done_x | output | 10 | X start of the last rectangle |
| done_y | output | 9 | Y start of the last rectangle |
| done_w | output | 11 | Width of the last rectangle |
| done_h | output | 10 | Height of the last rectangle |

## Verification
The assertions assume three things about the block's inputs:
- Pixel memory returns read data exactly one cycle after `mem_re`.
- The host holds a word on `in_data` until the word is taken.
- The host pops only a word that `rd_valid` has shown.

The bench keeps within these assumptions. Its memory model has a one-cycle read latency. Its push task leaves `in_valid` high until it sees `in_ready`, and its pop task first waits for `rd_valid`. Random gaps are inserted between words, and random bits are placed in the ignored header fields. These rules hold no matter where a pause falls relative to a row end.

// File: rtl/fbx_pkg.sv
package fbx_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POS,
        S_SIZE,
        S_WTAKE,
        S_WLO,
        S_WHI,
        S_WFIN,
        S_RLO,
        S_RCAPLO,
        S_RCAPHI,
        S_ROUT
    } xfer_state_e;

    function automatic logic op_is_xfer(input logic [7:0] op);
        return (op[7:5] == 3'b101) || (op[7:5] == 3'b110);
    endfunction

    function automatic logic op_is_read(input logic [7:0] op);
        return (op & 8'hE0) == 8'hC0;
    endfunction

endpackage

// File: rtl/fbx_rect_decode.sv
module fbx_rect_decode #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic [XW-1:0] wfield,
    input  logic [YW-1:0] hfield,
    output logic [XW:0]   w,
    output logic [YW:0]   h
);
    logic [XW-1:0] wm1;
    logic [YW-1:0] hm1;

    // minus one, truncated to the field width, plus one: zero means full span
    always_comb begin
        wm1 = wfield - 1'b1;
        hm1 = hfield - 1'b1;
        w   = {1'b0, wm1} + (XW+1)'(1);
        h   = {1'b0, hm1} + (YW+1)'(1);
    end
endmodule

// File: rtl/fbx_raster_walker.sv
module fbx_raster_walker #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XW-1:0]   x0,
    input  logic [YW-1:0]   y0,
    input  logic [XW:0]     w,
    input  logic [YW:0]     h,
    input  logic            step,
    output logic [XW+YW-1:0] addr,
    output logic            last,
    output logic            done
);
    logic [XW-1:0] bx;
    logic [YW-1:0] cy;
    logic [XW-1:0] col;
    logic [XW:0]   wlen;
    logic [YW:0]   rem;
    logic          row_end;
    logic [XW-1:0] cx;

    always_comb begin
        row_end = (({1'b0, col} + (XW+1)'(1)) == wlen);
        cx      = bx + col;                 // wraps modulo 2**XW
        addr    = {cy, cx};
        done    = (rem == '0);
        last    = (rem == (YW+1)'(1)) && row_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bx   <= '0;
            cy   <= '0;
            col  <= '0;
            wlen <= '0;
            rem  <= '0;
        end else if (load) begin
            bx   <= x0;
            cy   <= y0;
            col  <= '0;
            wlen <= w;
            rem  <= h;
        end else if (step) begin
            if (row_end) begin
                col <= '0;
                cy  <= cy + 1'b1;           // wraps modulo 2**YW
                rem <= rem - 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    p_step_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !done);

    p_col_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ({1'b0, col} < wlen));
endmodule

// File: rtl/fb_rect_xfer.sv
module fb_rect_xfer
    import fbx_pkg::*;
#(
    parameter int XW = 10,
    parameter int YW = 9,
    parameter int PW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [2*PW-1:0]      in_data,
    output logic                 in_ready,
    output logic                 rd_valid,
    output logic [2*PW-1:0]      rd_data,
    input  logic                 rd_pop,
    output logic [XW+YW-1:0]     mem_addr,
    output logic                 mem_we,
    output logic [PW-1:0]        mem_wdata,
    output logic                 mem_re,
    input  logic [PW-1:0]        mem_rdata,
    output logic                 busy,
    output logic                 img_ready,
    output logic                 wr_done,
    output logic [XW-1:0]        done_x,
    output logic [YW-1:0]        done_y,
    output logic [XW:0]          done_w,
    output logic [YW:0]          done_h
);
    localparam int DW = 2 * PW;

    xfer_state_e   state, nxt;
    logic          is_rd_q;
    logic [XW-1:0] px_q;
    logic [YW-1:0] py_q;
    logic [XW:0]   rw_q, dec_w;
    logic [YW:0]   rh_q, dec_h;
    logic [DW-1:0] wword_q, rword_q;
    logic          w_load, w_step, w_last, w_done;
    logic          take;

    assign take = in_valid && in_ready;

    fbx_rect_decode #(.XW(XW), .YW(YW)) u_dec (
        .wfield (in_data[XW-1:0]),
        .hfield (in_data[PW +: YW]),
        .w      (dec_w),
        .h      (dec_h)
    );

    fbx_raster_walker #(.XW(XW), .YW(YW)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (w_load),
        .x0    (px_q),
        .y0    (py_q),
        .w     (dec_w),
        .h     (dec_h),
        .step  (w_step),
        .addr  (mem_addr),
        .last  (w_last),
        .done  (w_done)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (in_valid && op_is_xfer(in_data[DW-1 -: 8])) nxt = S_POS;
            S_POS:    if (in_valid) nxt = S_SIZE;
            S_SIZE:   if (in_valid) nxt = is_rd_q ? S_RLO : S_WTAKE;
            S_WTAKE:  if (in_valid) nxt = S_WLO;
            S_WLO:    nxt = w_last ? S_WFIN : S_WHI;
            S_WHI:    nxt = w_last ? S_WFIN : S_WTAKE;
            S_WFIN:   nxt = S_IDLE;
            S_RLO:    nxt = S_RCAPLO;
            S_RCAPLO: nxt = w_done ? S_ROUT : S_RCAPHI;
            S_RCAPHI: nxt = S_ROUT;
            S_ROUT:   if (rd_pop) nxt = w_done ? S_IDLE : S_RLO;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        w_step    = 1'b0;
        mem_wdata = wword_q[PW-1:0];
        rd_valid  = 1'b0;
        wr_done   = 1'b0;
        img_ready = 1'b0;
        unique case (state)
            S_IDLE, S_POS, S_WTAKE: in_ready = 1'b1;
            S_SIZE:   in_ready = 1'b1;
            S_WLO:    begin mem_we = 1'b1; w_step = 1'b1; end
            S_WHI:    begin mem_we = 1'b1; w_step = 1'b1; mem_wdata = wword_q[DW-1:PW]; end
            S_WFIN:   wr_done = 1'b1;
            S_RLO:    begin mem_re = 1'b1; w_step = 1'b1; img_ready = 1'b1; end
            S_RCAPLO: begin mem_re = !w_done; w_step = !w_done; img_ready = 1'b1; end
            S_RCAPHI: img_ready = 1'b1;
            S_ROUT:   begin rd_valid = 1'b1; img_ready = 1'b1; end
            default:  ;
        endcase
        w_load = (state == S_SIZE) && in_valid;
        busy   = (state != S_IDLE);
    end

    assign rd_data = rword_q;
    assign done_x  = px_q;
    assign done_y  = py_q;
    assign done_w  = rw_q;
    assign done_h  = rh_q;

    // state register and datapath latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            is_rd_q <= 1'b0;
            px_q    <= '0;
            py_q    <= '0;
            rw_q    <= '0;
            rh_q    <= '0;
            wword_q <= '0;
            rword_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && take) is_rd_q <= op_is_read(in_data[DW-1 -: 8]);
            if (state == S_POS && take) begin
                px_q <= in_data[XW-1:0];
                py_q <= in_data[PW +: YW];
            end
            if (state == S_SIZE && take) begin
                rw_q <= dec_w;
                rh_q <= dec_h;
            end
            if (state == S_WTAKE && take) wword_q <= in_data;
            if (state == S_RCAPLO) rword_q <= {{PW{1'b0}}, mem_rdata};
            if (state == S_RCAPHI) rword_q[DW-1:PW] <= mem_rdata;
        end
    end

    p_acc_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    p_img_in_xfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready |-> busy);

    p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_pop) |=> (rd_valid && $stable(rd_data)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (!wr_done && !busy));
endmodule

// File: tb/fb_rect_xfer_bench.sv
`timescale 1ns/1ps
module fb_rect_xfer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_pop = 1'b0;
    logic [18:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic        mem_re;
    logic [15:0] mem_rdata = '0;
    logic        busy, img_ready, wr_done;
    logic [9:0]  done_x;
    logic [8:0]  done_y;
    logic [10:0] done_w;
    logic [9:0]  done_h;

    int n_chk = 0;
    int n_bad = 0;
    int wr_count = 0;
    int dn_cnt = 0;
    int cap_x, cap_y, cap_w, cap_h;

    logic [15:0] fb     [int];
    logic [15:0] shadow [int];

    always #2.5 clk = ~clk;

    fb_rect_xfer u_fb_rect_xfer (
        .clk, .rst_n, .in_valid, .in_data, .in_ready, .rd_valid, .rd_data, .rd_pop,
        .mem_addr, .mem_we, .mem_wdata, .mem_re, .mem_rdata,
        .busy, .img_ready, .wr_done, .done_x, .done_y, .done_w, .done_h
    );

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 37 + 11);
    endfunction

    function automatic logic [15:0] fb_get(input int a);
        return fb.exists(a) ? fb[a] : pat(a);
    endfunction

    function automatic logic [15:0] sh_get(input int a);
        return shadow.exists(a) ? shadow[a] : pat(a);
    endfunction

    function automatic int dec_w(input logic [31:0] s);
        int f = int'(s[15:0]) % 1024;
        return (f == 0) ? 1024 : f;
    endfunction

    function automatic int dec_h(input logic [31:0] s);
        int f = int'(s[31:16]) % 512;
        return (f == 0) ? 512 : f;
    endfunction

    function automatic int paddr(input int x0, input int y0, input int w, input int k);
        return ((y0 + k / w) % 512) * 1024 + ((x0 + k % w) % 1024);
    endfunction

    // pixel memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= fb_get(int'(mem_addr));
        if (mem_we) begin
            fb[int'(mem_addr)] = mem_wdata;
            wr_count++;
        end
    end

    always @(negedge clk) begin
        if (wr_done) begin
            dn_cnt++;
            cap_x = int'(done_x); cap_y = int'(done_y);
            cap_w = int'(done_w); cap_h = int'(done_h);
        end
    end

    task automatic chk(input string req, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_data  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic maybe_gap(input bit gaps);
        if (gaps && ($urandom % 3 == 0)) repeat (1 + $urandom % 4) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] op, input logic [31:0] posw,
                            input logic [31:0] sizew, input bit gaps, input string tag);
        int x0 = int'(posw[9:0]);
        int y0 = int'(posw[24:16]);
        int w = dec_w(sizew);
        int h = dec_h(sizew);
        int npix = w * h;
        int nw = (npix + 1) / 2;
        int wc0 = wr_count;
        int dc0 = dn_cnt;
        int mism = 0;
        push({op, 24'($urandom)});
        push(posw);
        push(sizew);
        for (int j = 0; j < nw; j++) begin
            logic [15:0] lo = 16'($urandom);
            logic [15:0] hi = 16'($urandom);
            shadow[paddr(x0, y0, w, 2*j)] = lo;
            if (2*j + 1 < npix) shadow[paddr(x0, y0, w, 2*j + 1)] = hi;
            maybe_gap(gaps);
            push({hi, lo});
        end
        do @(negedge clk); while (busy);
        chk({tag, " R8 pixel writes"}, wr_count - wc0, npix);
        chk({tag, " R9 done pulses"}, dn_cnt - dc0, 1);
        chk({tag, " R9 R3 done_x"}, cap_x, x0);
        chk({tag, " R9 R3 done_y"}, cap_y, y0);
        chk({tag, " R9 R4 done_w"}, cap_w, w);
        chk({tag, " R9 R4 done_h"}, cap_h, h);
        for (int k = 0; k < npix; k++)
            if (fb_get(paddr(x0, y0, w, k)) != sh_get(paddr(x0, y0, w, k))) mism++;
        chk({tag, " R5 R7 memory mismatches"}, mism, 0);
    endtask

    task automatic do_read(input logic [7:0] op, input logic [31:0] posw,
                           input logic [31:0] sizew, input bit gaps, input string tag);
        int x0 = int'(posw[9:0]);
        int y0 = int'(posw[24:16]);
        int w = dec_w(sizew);
        int h = dec_h(sizew);
        int npix = w * h;
        int nw = (npix + 1) / 2;
        int wc0 = wr_count;
        push({op, 24'($urandom)});
        push(posw);
        push(sizew);
        for (int j = 0; j < nw; j++) begin
            logic [15:0] lo = sh_get(paddr(x0, y0, w, 2*j));
            logic [15:0] hi = (2*j + 1 < npix) ? sh_get(paddr(x0, y0, w, 2*j + 1)) : 16'h0;
            maybe_gap(gaps);
            @(negedge clk);
            while (!rd_valid) @(negedge clk);
            if (j == 0) begin
                chk({tag, " R11 img_ready at start"}, img_ready, 1);
                chk({tag, " R10 preloaded word"}, rd_data, {hi, lo});
            end else if (j == nw - 1 && (npix % 2) == 1) begin
                chk({tag, " R12 odd tail word"}, rd_data, {hi, lo});
            end else begin
                chk({tag, " R5 R6 read word"}, rd_data, {hi, lo});
            end
            rd_pop = 1'b1;
            @(posedge clk);
            #1 rd_pop = 1'b0;
        end
        @(negedge clk);
        chk({tag, " R11 img_ready after end"}, img_ready, 0);
        chk({tag, " R11 busy after end"}, busy, 0);
        chk({tag, " R2 read wrote nothing"}, wr_count - wc0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R6 act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_ready", in_ready, 1);
        chk("R1 busy", busy, 0);
        chk("R1 img_ready", img_ready, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 mem_we/re", {mem_we, mem_re}, 0);
        chk("R1 wr_done", wr_done, 0);

        // R2: non-transfer opcodes are swallowed
        begin
            logic [31:0] junk [4] = '{32'hE1000000, 32'h9FFFFFFF, 32'h02FF00FF, 32'hE0123456};
            int wc0 = wr_count;
            foreach (junk[i]) begin
                push(junk[i]);
                @(negedge clk);
                chk("R2 ignored opcode busy", busy, 0);
                chk("R2 ignored opcode img_ready", img_ready, 0);
            end
            chk("R2 ignored opcode writes", wr_count - wc0, 0);
        end

        // directed: small rectangle, no gaps
        do_write(8'hA0, {7'h0, 9'd7, 6'h0, 10'd5}, {16'd2, 16'd3}, 1'b0, "D1 R5");
        do_read (8'hDF, {7'h0, 9'd7, 6'h0, 10'd5}, {16'd2, 16'd3}, 1'b0, "D1 R10");
        // directed: wrap in both axes with junk header bits and gaps
        do_write(8'hBF, {7'h55, 9'd511, 6'h2A, 10'd1022}, {16'hFE03, 16'hFC04}, 1'b1, "D2 R7 R3");
        do_read (8'hC0, {7'h55, 9'd511, 6'h2A, 10'd1022}, {16'hFE03, 16'hFC04}, 1'b1, "D2 R7");
        // directed: odd pixel count, read tail halfword zero
        do_write(8'hB3, {7'h0, 9'd100, 6'h0, 10'd200}, {16'd1, 16'd3}, 1'b1, "D3 R8");
        do_read (8'hD5, {7'h0, 9'd100, 6'h0, 10'd200}, {16'd1, 16'd3}, 1'b1, "D3 R12");
        // directed: zero width field means 1024, zero height field means 512
        do_write(8'hA7, {7'h0, 9'd300, 6'h0, 10'd17}, {16'd1, 16'h0400}, 1'b0, "D4 R4 width");
        do_write(8'hAC, {7'h0, 9'd40, 6'h0, 10'd900}, {16'h0200, 16'd1}, 1'b0, "D5 R4 height");
        do_read (8'hCF, {7'h0, 9'd40, 6'h0, 10'd900}, {16'd5, 16'd1}, 1'b1, "D5 R4 readback");

        // random rectangles, write then read back
        for (int i = 0; i < 20; i++) begin
            logic [31:0] posw, sizew;
            logic [7:0] wop, rop;
            posw  = ($urandom & 32'hFE00FC00) | (($urandom % 512) << 16) | ($urandom % 1024);
            sizew = ($urandom & 32'hFE00FC00) | ((1 + $urandom % 6) << 16) | (1 + $urandom % 24);
            wop = 8'hA0 + 8'($urandom % 32);
            rop = 8'hC0 + 8'($urandom % 32);
            do_write(wop, posw, sizew, 1'b1, "RND R6");
            do_read (rop, posw, sizew, 1'b1, "RND R6");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule